// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block decides when an asynchronous x4 dynamic memory must be refreshed. It runs from a system clock whose frequency is a parameter. It turns the timing rules of the memory, which are given in microseconds, into cycle counts. It does not drive the row or column strobes. It hands refresh work to an access sequencer through a request and grant pair. The sequencer runs the refresh cycle itself, either with a strobe-ordered refresh or with a row-only refresh that uses the row number supplied here.

After reset, no memory cycle of any kind is allowed until a power-up wait has elapsed. The block then asks for a fixed burst of start-up refreshes. Normal traffic is allowed only after the sequencer has granted every refresh in that burst, and the block signals this on `initDone`.

From then on, an interval timer adds one owed refresh each time a full refresh window divided by the row count has passed. The window is the standard one, or a longer one when low-power timing is selected. Owed refreshes build up to a bounded backlog, so the sequencer may delay them behind accesses. When the backlog is full the block raises an urgent flag.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `refReq`, `refUrgent` and `initDone` are 0, and `owedCount` and `refRow` are 0.
- R2: For the first CLK_MHZ*POWERUP_US cycles after reset is released, `refReq` stays 0, and a `refGrant` in that time changes nothing: `refRow` stays 0.
- R3: Once the power-up wait ends, `refReq` stays at 1 until INIT_REFRESHES grants have been accepted. A grant is accepted in a cycle where both `refReq` and `refGrant` are 1.
- R4: `initDone` becomes 1 in the cycle after the last start-up grant is accepted, and it stays at 1 until the next reset.
- R5: When `initDone` is 1 and `lowPower` is 0, `owedCount` rises by one every CLK_MHZ*STD_WINDOW_US/ROWS cycles (integer division) if no grant is accepted. The timer starts at 0 when `initDone` rises.
- R6: When `lowPower` is 1, the interval is CLK_MHZ*LP_WINDOW_US/ROWS cycles instead.
- R7: `owedCount` never exceeds BACKLOG_MAX. Each accepted grant after start-up lowers it by one. If a grant and an interval tick fall in the same cycle, the count is unchanged.
- R8: `refUrgent` is 1 exactly when `initDone` is 1 and `owedCount` equals BACKLOG_MAX.
- R9: After start-up, `refReq` is 1 exactly when `owedCount` is nonzero. A `refGrant` while `refReq` is 0 is ignored: `owedCount` and `refRow` do not change because of it.
- R10: `refRow` rises by one after each accepted grant, whether in the start-up burst or later, and wraps from ROWS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lowPower | input | 1 | Selects the long (low-power) refresh interval |
| refGrant | input | 1 | Sequencer runs the requested refresh this cycle |
| refReq | output | 1 | A refresh is wanted |
| refUrgent | output | 1 | Backlog full; the next cycle must be a refresh |
| initDone | output | 1 | Power-up wait and start-up burst are complete |
| owedCount | output | $clog2(BACKLOG_MAX+1) | Refreshes currently owed |
| refRow | output | $clog2(ROWS) | Row to refresh for a row-only refresh |

## Verification
Every output comes straight from a register or from a simple function of registers. An accepted grant or an interval tick therefore shows on `refRow`, `owedCount`, `refReq` and `refUrgent` one clock edge later, and `initDone` rises on the edge that takes the final start-up grant. The phase change at the end of power-up is seen on the edge after the counter reaches its last value. The bench drives inputs just after each falling edge. It steps a behavioural model on each rising edge and compares all five outputs at the next falling edge, so each result is checked in the cycle it is due. It also measures the gaps between increments and checks the standard and low-power intervals exactly.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [1:0] {
    PH_PWRUP = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic initPhase;  // start-up burst in progress
    logic runPhase;   // periodic refresh operation
    logic grantAcc;   // a requested refresh was granted this cycle
  } refStrobe_t;

endpackage

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int PWR_CYC        = 20000,
  parameter int INIT_REFRESHES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  logic       pendingNz,
  output refStrobe_t strb,
  output logic       refReq,
  output logic       initDone
);

  localparam int PW = $clog2(PWR_CYC + 1);
  localparam int IW = $clog2(INIT_REFRESHES + 1);

  phase_t          phase;
  logic [PW-1:0]   pwrCnt;
  logic [IW-1:0]   initLeft;
  logic            inInit;
  logic            inRun;

  assign inInit = (phase == PH_INIT);
  assign inRun  = (phase == PH_RUN);

  always_comb begin
    refReq         = inInit || (inRun && pendingNz);
    strb.initPhase = inInit;
    strb.runPhase  = inRun;
    strb.grantAcc  = refReq && refGrant;
  end

  assign initDone = inRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_PWRUP;
      pwrCnt   <= '0;
      initLeft <= '0;
    end else begin
      case (phase)
        PH_PWRUP: begin
          if (pwrCnt == PW'(PWR_CYC - 1)) begin
            phase    <= PH_INIT;
            initLeft <= IW'(INIT_REFRESHES);
          end else begin
            pwrCnt <= pwrCnt + 1'b1;
          end
        end
        PH_INIT: begin
          if (strb.grantAcc) begin
            if (initLeft == IW'(1)) phase <= PH_RUN;
            initLeft <= initLeft - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int ROWS        = 512,
  parameter int BACKLOG_MAX = 8,
  parameter int STD_INT     = 3125,
  parameter int LP_INT      = 25000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lowPower,
  input  refStrobe_t                     strb,
  output logic                           pendingNz,
  output logic                           urgent,
  output logic [$clog2(BACKLOG_MAX+1)-1:0] owed,
  output logic [$clog2(ROWS)-1:0]        row
);

  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(BACKLOG_MAX + 1);
  localparam int MAXI = (LP_INT > STD_INT) ? LP_INT : STD_INT;
  localparam int TW   = $clog2(MAXI + 1);

  logic [TW-1:0] tmr;
  logic [TW-1:0] limM1;
  logic          tick;
  logic          accRun;
  logic [CW:0]   sumW;
  logic [CW-1:0] owedNext;
  logic [RW-1:0] rowNext;

  // interval timer
  assign limM1 = lowPower ? TW'(LP_INT - 1) : TW'(STD_INT - 1);
  assign tick  = strb.runPhase && (tmr >= limM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (!strb.runPhase) tmr <= '0;
    else if (tick)          tmr <= '0;
    else                    tmr <= tmr + 1'b1;
  end

  // owed-refresh backlog
  assign accRun = strb.runPhase && strb.grantAcc;

  always_comb begin
    sumW = {1'b0, owed} + (CW+1)'(tick) - (CW+1)'(accRun);
    if (sumW > (CW+1)'(BACKLOG_MAX)) owedNext = CW'(BACKLOG_MAX);
    else                             owedNext = sumW[CW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               owed <= '0;
    else if (!strb.runPhase) owed <= '0;
    else                     owed <= owedNext;
  end

  assign pendingNz = (owed != '0);
  assign urgent    = strb.runPhase && (owed == CW'(BACKLOG_MAX));

  // refresh row counter, wrap chosen by whether ROWS fills the field
  generate
    if ((1 << RW) == ROWS) begin : g_rowPow2
      assign rowNext = row + 1'b1;
    end else begin : g_rowMod
      assign rowNext = (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              row <= '0;
    else if (strb.grantAcc) row <= rowNext;
  end

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int CLK_MHZ        = 200,
  parameter int POWERUP_US     = 100,
  parameter int STD_WINDOW_US  = 8000,
  parameter int LP_WINDOW_US   = 64000,
  parameter int ROWS           = 512,
  parameter int INIT_REFRESHES = 8,
  parameter int BACKLOG_MAX    = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             lowPower,
  input  logic                             refGrant,
  output logic                             refReq,
  output logic                             refUrgent,
  output logic                             initDone,
  output logic [$clog2(BACKLOG_MAX+1)-1:0] owedCount,
  output logic [$clog2(ROWS)-1:0]          refRow
);

  localparam int PWR_CYC = CLK_MHZ * POWERUP_US;
  localparam int STD_INT = (CLK_MHZ * STD_WINDOW_US) / ROWS;
  localparam int LP_INT  = (CLK_MHZ * LP_WINDOW_US) / ROWS;

  refStrobe_t strb;
  logic       pendingNz;

  refsched_ctrl #(
    .PWR_CYC       (PWR_CYC),
    .INIT_REFRESHES(INIT_REFRESHES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .pendingNz(pendingNz),
    .strb     (strb),
    .refReq   (refReq),
    .initDone (initDone)
  );

  refsched_dp #(
    .ROWS       (ROWS),
    .BACKLOG_MAX(BACKLOG_MAX),
    .STD_INT    (STD_INT),
    .LP_INT     (LP_INT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lowPower (lowPower),
    .strb     (strb),
    .pendingNz(pendingNz),
    .urgent   (refUrgent),
    .owed     (owedCount),
    .row      (refRow)
  );

endmodule

// File: rtl/refresh_scheduler_checker.sv
module refresh_scheduler_checker #(
  parameter int PWR_CYC     = 20000,
  parameter int ROWS        = 512,
  parameter int BACKLOG_MAX = 8
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             refGrant,
  input logic                             refReq,
  input logic                             refUrgent,
  input logic                             initDone,
  input logic [$clog2(BACKLOG_MAX+1)-1:0] owedCount,
  input logic [$clog2(ROWS)-1:0]          refRow
);

  localparam int RW = $clog2(ROWS);

  logic [31:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cyc <= '0;
    else if (cyc != 32'hFFFF_FFFF) cyc <= cyc + 1;
  end

  assert_quiet_powerup_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc < 32'(PWR_CYC)) |-> !refReq);

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(owedCount) <= BACKLOG_MAX);

  assert_urgent_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent == (initDone && int'(owedCount) == BACKLOG_MAX));

  assert_req_backlog_R9: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (refReq == (owedCount != '0)));

  assert_row_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant) |=>
      refRow == (($past(refRow) == RW'(ROWS - 1)) ? '0 : $past(refRow) + 1'b1));

  assert_row_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(refReq && refGrant) |=> $stable(refRow));

endmodule

bind refresh_scheduler refresh_scheduler_checker #(
  .PWR_CYC    (PWR_CYC),
  .ROWS       (ROWS),
  .BACKLOG_MAX(BACKLOG_MAX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .refGrant (refGrant),
  .refReq   (refReq),
  .refUrgent(refUrgent),
  .initDone (initDone),
  .owedCount(owedCount),
  .refRow   (refRow)
);

// File: tb/refresh_scheduler_bench.sv
`timescale 1ns/1ps
module refresh_scheduler_bench;

  localparam int CLK_MHZ = 1;
  localparam int PWRUS   = 40;
  localparam int STDW    = 8000;
  localparam int LPW     = 64000;
  localparam int ROWS    = 512;
  localparam int NINIT   = 8;
  localparam int BMAX    = 8;
  localparam int PWR     = CLK_MHZ * PWRUS;
  localparam int STDI    = (CLK_MHZ * STDW) / ROWS;
  localparam int LPI     = (CLK_MHZ * LPW) / ROWS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowPower = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, refUrgent, initDone;
  logic [$clog2(BMAX+1)-1:0] owedCount;
  logic [$clog2(ROWS)-1:0]   refRow;

  always #2.5 clk = ~clk;

  refresh_scheduler #(
    .CLK_MHZ(CLK_MHZ), .POWERUP_US(PWRUS), .STD_WINDOW_US(STDW),
    .LP_WINDOW_US(LPW), .ROWS(ROWS), .INIT_REFRESHES(NINIT), .BACKLOG_MAX(BMAX)
  ) u_refresh_scheduler (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .refGrant(refGrant),
    .refReq(refReq), .refUrgent(refUrgent), .initDone(initDone),
    .owedCount(owedCount), .refRow(refRow)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural reference
  int mPhase, mPwr, mInit, mTmr, mPend, mRow;
  function automatic bit mReq();
    return (mPhase == 1) || (mPhase == 2 && mPend > 0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mPwr = 0; mInit = 0; mTmr = 0; mPend = 0; mRow = 0;
    end else begin
      bit acc, tk;
      int lim;
      acc = refGrant && mReq();
      if (acc) mRow = (mRow + 1) % ROWS;
      if (mPhase == 0) begin
        if (mPwr == PWR - 1) begin mPhase = 1; mInit = NINIT; end
        else mPwr++;
      end else if (mPhase == 1) begin
        if (acc) begin
          if (mInit == 1) begin mPhase = 2; mTmr = 0; mPend = 0; end
          mInit--;
        end
      end else begin
        lim = lowPower ? LPI : STDI;
        tk = (mTmr >= lim - 1);
        mTmr = tk ? 0 : mTmr + 1;
        mPend = mPend - int'(acc) + int'(tk);
        if (mPend > BMAX) mPend = BMAX;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compareAll();
    string rq;
    rq = (mPhase == 0) ? "R2" : (mPhase == 1) ? "R3" : "R9";
    chk(refReq == mReq(), rq, int'(refReq), int'(mReq()), "refReq");
    chk(refUrgent == (mPhase == 2 && mPend == BMAX), "R8", int'(refUrgent),
        int'(mPhase == 2 && mPend == BMAX), "refUrgent");
    chk(initDone == (mPhase == 2), "R4", int'(initDone), int'(mPhase == 2), "initDone");
    chk(int'(owedCount) == mPend, "R7", int'(owedCount), mPend, "owedCount");
    chk(int'(refRow) == mRow, "R10", int'(refRow), mRow, "refRow");
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      compareAll();
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int t0, gap, guard;
    refGrant = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: state under reset
    chk(!refReq && !refUrgent && !initDone && owedCount == '0 && refRow == '0,
        "R1", int'(refReq), 0, "reset outputs");
    rstN = 1'b1;
    step(1);
    chk(!refReq && !initDone && refRow == '0, "R1", int'(refRow), 0, "first cycle after reset");
    // R2: grants during the wait are ignored
    step(20);
    chk(refRow == '0 && !refReq, "R2", int'(refRow), 0, "row during power-up");
    refGrant = 1'b0;
    step(PWR - 20);
    chk(refReq == 1'b1, "R3", int'(refReq), 1, "request at end of wait");
    // R3: spaced start-up grants
    for (int g = 0; g < NINIT; g++) begin
      refGrant = 1'b1; step(1);
      refGrant = 1'b0; step(2);
    end
    chk(initDone == 1'b1 && int'(refRow) == NINIT, "R4", int'(refRow), NINIT, "burst complete");
    // R5: standard interval gap
    guard = 0;
    while (owedCount == '0 && guard < 1000) begin step(1); guard++; end
    t0 = cyc;
    guard = 0;
    while (int'(owedCount) < 2 && guard < 1000) begin step(1); guard++; end
    gap = cyc - t0;
    chk(gap == STDI, "R5", gap, STDI, "standard interval");
    // R7/R8: saturate
    step(STDI * (BMAX + 2));
    chk(int'(owedCount) == BMAX && refUrgent, "R7", int'(owedCount), BMAX, "saturated backlog");
    chk(refUrgent == 1'b1, "R8", int'(refUrgent), 1, "urgent when full");
    // drain partly
    refGrant = 1'b1; step(5);
    refGrant = 1'b0; step(3);
    // R9: drain fully then a stray grant is ignored
    refGrant = 1'b1;
    guard = 0;
    while (owedCount != '0 && guard < 100) begin step(1); guard++; end
    refGrant = 1'b0; step(1);
    t0 = int'(refRow);
    if (owedCount == '0) begin
      refGrant = 1'b1; step(1); refGrant = 1'b0;
      chk(int'(refRow) == t0, "R9", int'(refRow), t0, "stray grant row");
    end
    // R10: grant continuously until the row wraps
    refGrant = 1'b1;
    guard = 0;
    while (mRow != ROWS - 1 && guard < 20000) begin step(1); guard++; end
    guard = 0;
    while (mRow == ROWS - 1 && guard < 100) begin step(1); guard++; end
    chk(refRow == '0, "R10", int'(refRow), 0, "row wrap");
    // R6: low-power interval
    lowPower = 1'b1;
    guard = 0;
    while (owedCount != '0 && guard < 100) begin step(1); guard++; end
    refGrant = 1'b0;
    guard = 0;
    while (owedCount == '0 && guard < 1000) begin step(1); guard++; end
    t0 = cyc;
    guard = 0;
    while (int'(owedCount) < 2 && guard < 1000) begin step(1); guard++; end
    gap = cyc - t0;
    chk(gap == LPI, "R6", gap, LPI, "low-power interval");
    // R7: tick and grant together at full backlog
    step(LPI * (BMAX + 1));
    refGrant = 1'b1;
    step(LPI * 2);
    refGrant = 1'b0;
    step(10);
    summary();
  end

endmodule